// File: doc/BRIEF.md
# Memory-Mapped to Register-Bus Bridge

The bridge lets a processor reach an internal register bus through a window of 64-bit memory-mapped accesses. It takes the byte offset of each access within the window and turns it into a register index. Two chip-generation modes are supported, and each builds the index in its own way. A small table of housekeeping indices is answered inside the bridge. Some of those reads return fixed values, and some of those writes are accepted and then thrown away. Every other access is sent to a downstream register port, which returns a response and an error flag.

The bridge never gives an error response on the memory-mapped side. It records the result of each access in two sticky status bits, DONE and FAIL, which software or an interrupt block reads on the `status` port. It handles one access at a time. The master holds its request until `mmio_ready` pulses.

Top module: `mmio_regbus_bridge`

## Requirements
- R1: Address bits at or above `WIN_BITS` (35) are ignored, so an offset that differs from another only in those bits addresses the same register.
- R2: With `gen_new`=0 (older generation), index bits [3:0] are offset bits [6:3], index bits [31:4] are offset bits [35:8], and offset bit 7 is dropped. The downstream byte address `ds_addr` is the index times 8.
- R3: With `gen_new`=1 (newer generation), the index is the offset divided by 8, and `ds_addr` is the index times 8.
- R4: A read of index 0xF000F returns `chip_id` without any downstream request. A write to index 0xF000F completes with DONE and changes nothing.
- R5: Reads of the housekeeping indices 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, 0x2013F01, 0x2013F05, 0x2013028, 0x201302A, 0x2013801, 0x2013802, and 0x2010828/82A/841/842 and 0x4010828/82A/841/842 return zero with no downstream request.
- R6: Writes to 0xF000F, 0x1010C00 through 0x1010C05, the log, error and receive-status indices of R5, the four poll indices, and the twelve coprocessor indices of R5 complete with DONE only, and no downstream request is made.
- R7: Every other access of size 8 raises `ds_req` with `ds_addr` = index×8, `ds_we` equal to the access direction, and the write data.
- R8: A downstream response with `ds_err`=1 sets both FAIL (`status[1]`) and DONE (`status[0]`), and a read completed this way returns zero.
- R9: A successful access, handled either locally or downstream, sets DONE and leaves FAIL unchanged.
- R10: Both status bits are sticky. Each clears only when its own `sts_clr` bit is 1 or on reset. A set in the same cycle as a clear wins.
- R11: An access whose `mmio_size` is not 8 (bytes) sets DONE and FAIL, returns zero, and makes no downstream request.
- R12: Data is big-endian. Byte k of `mmio_wdata` (bits 8k+7:8k) becomes byte 7−k of `ds_wdata`, and the same swap is applied to `ds_rdata` and `chip_id` on the way back to `mmio_rdata`.
- R13: If no `ds_ack` arrives within `TO_CYC` cycles of `ds_req`, the request is dropped, DONE and FAIL are set, and zero is returned.
- R14: `mmio_ready` is a one-cycle pulse. A local access completes one cycle after it is accepted. A downstream access completes one cycle after `ds_ack`, and `ds_req` stays high until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| gen_new | input | 1 | Address-translation mode: 0 older, 1 newer |
| chip_id | input | 64 | Identification value returned for index 0xF000F |
| mmio_req | input | 1 | Access request, held until `mmio_ready` |
| mmio_we | input | 1 | 1 write, 0 read |
| mmio_addr | input | AW (40) | Byte offset of the access |
| mmio_size | input | 4 | Access size in bytes |
| mmio_wdata | input | 64 | Write data |
| mmio_ready | output | 1 | Completion pulse |
| mmio_rdata | output | 64 | Read data, valid with `mmio_ready` |
| ds_req | output | 1 | Downstream request, held until acknowledged or timed out |
| ds_we | output | 1 | Downstream direction |
| ds_addr | output | WIN_BITS (35) | Downstream byte address (index×8) |
| ds_wdata | output | 64 | Downstream write data |
| ds_ack | input | 1 | Downstream response strobe |
| ds_err | input | 1 | Downstream failure flag, valid with `ds_ack` |
| ds_rdata | input | 64 | Downstream read data, valid with `ds_ack` |
| sts_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| status | output | 2 | Bit 0 DONE, bit 1 FAIL |

## Verification
The address translation is driven with a walking single bit and with a walking bit plus a filled low nibble, from bit 3 to bit 39, in both modes. The walking bit separates the two bit mappings and shows where offset bit 7 is dropped. The filled nibble shows that the low index bits are kept, and the bits at or above the window show the aliasing. Every housekeeping index is then both read and written in both modes, which separates the read-answered set from the write-dropped set. Downstream accesses are run with several response latencies, with an error response and with no response at all, which separates success, failure and timeout in the status bits and in the completion timing.

// File: rtl/rbb_pkg.sv
package rbb_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} rbb_state_e;

  typedef struct packed {
    logic rd_zero;
    logic rd_chipid;
    logic wr_drop;
  } rbb_loc_t;

  localparam int DONE_BIT = 0;
  localparam int FAIL_BIT = 1;

  // Big-endian lane swap between the memory-mapped side and the register bus
  function automatic logic [63:0] rbb_bswap64(input logic [63:0] d);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = d[8*(7-k) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/rbb_addr_xlate.sv
module rbb_addr_xlate #(
  parameter int AW       = 40,
  parameter int WIN_BITS = 35,
  parameter int IDX_W    = WIN_BITS - 3
) (
  input  logic [AW-1:0]    addr,
  input  logic             gen_new,
  output logic [IDX_W-1:0] idx
);

  function automatic logic [IDX_W-1:0] idx_newgen(input logic [WIN_BITS-1:0] off);
    logic [WIN_BITS-1:0] t;
    t = off >> 3;
    return t[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] idx_oldgen(input logic [WIN_BITS-1:0] off);
    logic [WIN_BITS-1:0] hi;
    logic [WIN_BITS-1:0] lo;
    hi      = off >> 4;
    hi[3:0] = 4'h0;
    lo      = {{(WIN_BITS-4){1'b0}}, off[6:3]};
    hi      = hi | lo;
    return hi[IDX_W-1:0];
  endfunction

  logic [WIN_BITS-1:0] win_off;
  assign win_off = addr[WIN_BITS-1:0];
  assign idx     = gen_new ? idx_newgen(win_off) : idx_oldgen(win_off);

endmodule

// File: rtl/rbb_local_decode.sv
module rbb_local_decode
  import rbb_pkg::*;
#(
  parameter int IDX_W = 32
) (
  input  logic [IDX_W-1:0] idx,
  output rbb_loc_t         loc
);

  logic [31:0] i32;
  assign i32 = 32'(idx);

  function automatic rbb_loc_t classify(input logic [31:0] i);
    rbb_loc_t c;
    c = '0;
    case (i)
      32'h000F000F: begin c.rd_chipid = 1'b1; c.wr_drop = 1'b1; end
      32'h01010C00, 32'h01010C03: begin c.rd_zero = 1'b1; c.wr_drop = 1'b1; end
      32'h01010C01, 32'h01010C02,
      32'h01010C04, 32'h01010C05: c.wr_drop = 1'b1;
      32'h01020013, 32'h01020014,
      32'h000F0033, 32'h000F0034: begin c.rd_zero = 1'b1; c.wr_drop = 1'b1; end
      32'h00090012, 32'h00090013, 32'h00090018,
      32'h02020007, 32'h02020009, 32'h0202000F: begin c.rd_zero = 1'b1; c.wr_drop = 1'b1; end
      32'h02013F01, 32'h02013F05: c.rd_zero = 1'b1;
      32'h02013028, 32'h0201302A, 32'h02013801, 32'h02013802,
      32'h02010828, 32'h0201082A, 32'h02010841, 32'h02010842,
      32'h04010828, 32'h0401082A, 32'h04010841, 32'h04010842: begin
        c.rd_zero = 1'b1; c.wr_drop = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  assign loc = classify(i32);

endmodule

// File: rtl/rbb_status.sv
module rbb_status
  import rbb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_fail,
  input  logic [1:0] clr,
  output logic [1:0] status
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 2'b00;
    end else begin
      status[DONE_BIT] <= set_done | (status[DONE_BIT] & ~clr[DONE_BIT]);
      status[FAIL_BIT] <= set_fail | (status[FAIL_BIT] & ~clr[FAIL_BIT]);
    end
  end

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[DONE_BIT] && !clr[DONE_BIT] |=> status[DONE_BIT]);
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[FAIL_BIT] && !clr[FAIL_BIT] |=> status[FAIL_BIT]);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> status[DONE_BIT]);
  assert_fail_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_fail |-> set_done);

endmodule

// File: rtl/mmio_regbus_bridge.sv
module mmio_regbus_bridge
  import rbb_pkg::*;
#(
  parameter int AW       = 40,
  parameter int WIN_BITS = 35,
  parameter int TO_CYC   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_new,
  input  logic [63:0]         chip_id,
  input  logic                mmio_req,
  input  logic                mmio_we,
  input  logic [AW-1:0]       mmio_addr,
  input  logic [3:0]          mmio_size,
  input  logic [63:0]         mmio_wdata,
  output logic                mmio_ready,
  output logic [63:0]         mmio_rdata,
  output logic                ds_req,
  output logic                ds_we,
  output logic [WIN_BITS-1:0] ds_addr,
  output logic [63:0]         ds_wdata,
  input  logic                ds_ack,
  input  logic                ds_err,
  input  logic [63:0]         ds_rdata,
  input  logic [1:0]          sts_clr,
  output logic [1:0]          status
);

  localparam int IDX_W = WIN_BITS - 3;
  localparam int TO_W  = $clog2(TO_CYC + 1);

  rbb_state_e      st;
  logic [IDX_W-1:0] idx;
  rbb_loc_t        loc;
  logic [TO_W-1:0] to_cnt;
  logic [63:0]     rdata_q;

  // Named events for the assertions
  logic acc_fire, size_ok, loc_hit, ds_done, to_hit, set_done, set_fail;

  rbb_addr_xlate #(.AW(AW), .WIN_BITS(WIN_BITS), .IDX_W(IDX_W)) u_xlate (
    .addr(mmio_addr), .gen_new(gen_new), .idx(idx)
  );

  rbb_local_decode #(.IDX_W(IDX_W)) u_loc (.idx(idx), .loc(loc));

  assign acc_fire = (st == ST_IDLE) && mmio_req;
  assign size_ok  = (mmio_size == 4'd8);
  assign loc_hit  = size_ok && (mmio_we ? loc.wr_drop : (loc.rd_zero | loc.rd_chipid));
  assign ds_done  = (st == ST_WAIT) && ds_ack;
  assign to_hit   = (st == ST_WAIT) && !ds_ack && (to_cnt == TO_W'(TO_CYC - 1));

  assign set_done = (acc_fire && (!size_ok || loc_hit)) || ds_done || to_hit;
  assign set_fail = (acc_fire && !size_ok) || (ds_done && ds_err) || to_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      to_cnt   <= '0;
      rdata_q  <= '0;
      ds_addr  <= '0;
      ds_we    <= 1'b0;
      ds_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: if (acc_fire) begin
          ds_addr  <= {idx, 3'b000};
          ds_we    <= mmio_we;
          ds_wdata <= rbb_bswap64(mmio_wdata);
          to_cnt   <= '0;
          if (!size_ok) begin
            rdata_q <= '0;
            st      <= ST_RESP;
          end else if (loc_hit) begin
            rdata_q <= (!mmio_we && loc.rd_chipid) ? rbb_bswap64(chip_id) : 64'h0;
            st      <= ST_RESP;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ds_ack) begin
            rdata_q <= (ds_err || ds_we) ? 64'h0 : rbb_bswap64(ds_rdata);
            st      <= ST_RESP;
          end else if (to_hit) begin
            rdata_q <= '0;
            st      <= ST_RESP;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mmio_ready = (st == ST_RESP);
  assign mmio_rdata = rdata_q;
  assign ds_req     = (st == ST_WAIT);

  rbb_status u_status (
    .clk(clk), .rst_n(rst_n), .set_done(set_done), .set_fail(set_fail),
    .clr(sts_clr), .status(status)
  );

  assert_ready_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_ready |=> !mmio_ready);
  assert_req_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && !ds_ack && !to_hit |=> ds_req && $stable(ds_addr));
  assert_local_no_ds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && loc_hit |=> mmio_ready && !ds_req);
  assert_badsize_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !size_ok |=> mmio_ready && !ds_req && status[FAIL_BIT]);
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ds_done && ds_err |=> mmio_ready && mmio_rdata == 64'h0 && status == 2'b11);
  assert_timeout_R13: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> mmio_ready && !ds_req && status[FAIL_BIT]);

endmodule

// File: tb/mmio_regbus_bridge_tb.sv
module mmio_regbus_bridge_tb;

  localparam int AW = 40;
  localparam int WB = 35;
  localparam int TO = 32;
  localparam logic [63:0] CHIP = 64'hC0DE_0000_1234_ABCD;

  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic rst_n = 1'b0, gen_new = 1'b0, mmio_req = 1'b0, mmio_we = 1'b0;
  logic [AW-1:0] mmio_addr = '0;
  logic [3:0] mmio_size = 4'd8;
  logic [63:0] mmio_wdata = '0, mmio_rdata, ds_wdata, ds_rdata = '0;
  logic mmio_ready, ds_req, ds_we, ds_ack = 1'b0, ds_err = 1'b0;
  logic [WB-1:0] ds_addr;
  logic [1:0] sts_clr = 2'b00, status;

  mmio_regbus_bridge #(.AW(AW), .WIN_BITS(WB), .TO_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .gen_new(gen_new), .chip_id(CHIP),
    .mmio_req(mmio_req), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
    .mmio_size(mmio_size), .mmio_wdata(mmio_wdata), .mmio_ready(mmio_ready),
    .mmio_rdata(mmio_rdata), .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_ack(ds_ack), .ds_err(ds_err), .ds_rdata(ds_rdata),
    .sts_clr(sts_clr), .status(status)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Downstream model
  int  lat = 0, lat_cnt = 0, ds_seen = 0;
  bit  err_mode = 0, no_ack = 0;
  logic [WB-1:0] cap_addr;
  logic [63:0]   cap_wdata;
  logic          cap_we;

  function automatic logic [63:0] ds_val(input logic [WB-1:0] a);
    return {29'h0, a} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  always @(negedge clk) begin
    if (ds_req) ds_seen++;
    if (ds_ack) begin
      ds_ack = 1'b0; ds_err = 1'b0;
    end else if (ds_req && !no_ack) begin
      if (lat_cnt == lat) begin
        ds_ack = 1'b1; ds_err = err_mode; ds_rdata = ds_val(ds_addr);
        cap_addr = ds_addr; cap_we = ds_we; cap_wdata = ds_wdata;
        lat_cnt = 0;
      end else lat_cnt++;
    end else lat_cnt = 0;
  end

  // Reference arithmetic
  function automatic logic [63:0] swap(input logic [63:0] d);
    logic [63:0] r = '0;
    for (int b = 0; b < 64; b++) r[(7 - b/8)*8 + b%8] = d[b];
    return r;
  endfunction

  function automatic logic [31:0] ref_idx(input bit g, input logic [AW-1:0] a);
    logic [63:0] off = 64'(a) % (64'd1 << WB);
    logic [31:0] r = '0;
    if (g) return 32'(off / 8);
    for (int k = 0; k < 32; k++) r[k] = (k < 4) ? off[k+3] : off[k+4];
    return r;
  endfunction

  function automatic logic [AW-1:0] off_of(input bit g, input logic [31:0] i);
    if (g) return AW'(i) * 8;
    return AW'(i / 16) * 256 + AW'(i % 16) * 8;
  endfunction

  logic [31:0] rz_list [26] = '{32'h1010C00, 32'h1010C03, 32'h1020013, 32'h1020014, 32'hF0033,
    32'hF0034, 32'h90018, 32'h90012, 32'h90013, 32'h2020007, 32'h2020009, 32'h202000F,
    32'h2013F01, 32'h2013F05, 32'h2013028, 32'h201302A, 32'h2013801, 32'h2013802,
    32'h2010841, 32'h2010842, 32'h201082A, 32'h2010828, 32'h4010841, 32'h4010842,
    32'h401082A, 32'h4010828};
  logic [31:0] wd_list [29] = '{32'hF000F, 32'h1010C00, 32'h1010C01, 32'h1010C02, 32'h1010C03,
    32'h1010C04, 32'h1010C05, 32'h90018, 32'h90012, 32'h90013, 32'h2020007, 32'h2020009,
    32'h202000F, 32'h2013028, 32'h201302A, 32'h2013801, 32'h2013802, 32'h2010841,
    32'h2010842, 32'h201082A, 32'h2010828, 32'h4010841, 32'h4010842, 32'h401082A,
    32'h4010828, 32'h1020013, 32'h1020014, 32'hF0033, 32'hF0034};

  logic [63:0] rd;
  int          ncyc;

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [63:0] wd,
                        input logic [3:0] sz);
    @(negedge clk);
    mmio_req = 1'b1; mmio_we = we; mmio_addr = a; mmio_wdata = wd; mmio_size = sz;
    ncyc = 0;
    do begin
      @(negedge clk);
      ncyc++;
    end while (!mmio_ready && ncyc < TO + 20);
    rd = mmio_rdata;
    mmio_req = 1'b0;
  endtask

  task automatic clear(input logic [1:0] v);
    @(negedge clk); sts_clr = v;
    @(negedge clk); sts_clr = 2'b00;
  endtask

  initial begin
    int s0;
    logic [AW-1:0] a;
    logic [31:0] ei;
    repeat (3) @(negedge clk);
    chk(status == 2'b00 && !mmio_ready && !ds_req, "R10 reset state", {62'h0, status}, 64'h0);
    rst_n = 1'b1;

    for (int g = 0; g < 2; g++) begin
      gen_new = g[0];
      // Local read-zero set (R5)
      foreach (rz_list[i]) begin
        clear(2'b11); s0 = ds_seen;
        access(0, off_of(g[0], rz_list[i]), 64'h0, 4'd8);
        chk(rd == 64'h0 && ds_seen == s0 && ncyc == 1, "R5 local read zero", rd, 64'h0);
        chk(status == 2'b01, "R9 local done only", {62'h0, status}, 64'h1);
      end
      // Local write-drop set (R6)
      foreach (wd_list[i]) begin
        clear(2'b11); s0 = ds_seen;
        access(1, off_of(g[0], wd_list[i]), 64'hFFFF_0000_FFFF_0000, 4'd8);
        chk(ds_seen == s0 && status == 2'b01 && ncyc == 1, "R6 write dropped",
            {62'h0, status}, 64'h1);
      end
      // Chip id (R4)
      access(1, off_of(g[0], 32'hF000F), 64'h0, 4'd8);
      access(0, off_of(g[0], 32'hF000F), 64'h0, 4'd8);
      chk(rd == swap(CHIP), "R4 chip id read, write ignored, R12 swap", rd, swap(CHIP));

      // Walking-bit translation sweep (R1 R2 R3 R7 R12)
      for (int b = 3; b < AW; b++) begin
        for (int v = 0; v < 2; v++) begin
          a = (AW'(1) << b) | (v ? AW'(8'h78) : AW'(0));
          ei = ref_idx(g[0], a);
          lat = b % 4;
          clear(2'b11);
          access(0, a, 64'h0, 4'd8);
          chk(cap_addr == WB'({ei, 3'b000}), b >= WB ? "R1 alias" : (g ? "R3 new idx" : "R2 old idx"),
              64'(cap_addr), 64'({ei, 3'b000}));
          chk(rd == swap(ds_val(cap_addr)) && ncyc == 2 + lat, "R7 R12 R14 read data/latency",
              rd, swap(ds_val(cap_addr)));
          chk(status == 2'b01, "R9 downstream ok", {62'h0, status}, 64'h1);
        end
      end
    end

    // Write forwarding with swap (R7 R12)
    gen_new = 1'b1; lat = 1;
    access(1, AW'(32'h123458), 64'h1122_3344_5566_7788, 4'd8);
    chk(cap_we && cap_wdata == 64'h8877_6655_4433_2211 && cap_addr == WB'(32'h123458),
        "R7 R12 write fwd", cap_wdata, 64'h8877_6655_4433_2211);

    // Downstream error (R8)
    clear(2'b11); err_mode = 1;
    access(0, AW'(32'h123458), 64'h0, 4'd8);
    chk(rd == 64'h0 && status == 2'b11, "R8 ds error read", {rd[61:0], status}, 64'h3);
    clear(2'b11);
    access(1, AW'(32'h123460), 64'h5, 4'd8);
    chk(status == 2'b11, "R8 ds error write", {62'h0, status}, 64'h3);
    err_mode = 0;

    // Sticky / per-bit clear (R10)
    clear(2'b10);
    chk(status == 2'b01, "R10 clear fail only", {62'h0, status}, 64'h1);
    access(0, off_of(1, 32'h90012), 64'h0, 4'd8);
    chk(status == 2'b01, "R10 success keeps fail clear", {62'h0, status}, 64'h1);
    clear(2'b01);
    chk(status == 2'b00, "R10 clear done", {62'h0, status}, 64'h0);
    // Set wins over simultaneous clear
    clear(2'b11);
    @(negedge clk);
    mmio_req = 1'b1; mmio_we = 1'b0; mmio_addr = off_of(1, 32'h90013); mmio_size = 4'd8;
    sts_clr = 2'b01;
    @(negedge clk);
    sts_clr = 2'b00;
    chk(mmio_ready && status == 2'b01, "R10 set wins", {62'h0, status}, 64'h1);
    mmio_req = 1'b0;

    // Bad size (R11)
    clear(2'b11); s0 = ds_seen;
    access(0, AW'(32'h123458), 64'h0, 4'd4);
    chk(rd == 64'h0 && status == 2'b11 && ds_seen == s0, "R11 bad size", {62'h0, status}, 64'h3);

    // Timeout (R13)
    clear(2'b11); no_ack = 1; s0 = ds_seen;
    access(0, AW'(32'h123458), 64'h0, 4'd8);
    chk(ncyc == TO + 1, "R13 timeout cycles", 64'(ncyc), 64'(TO + 1));
    chk(rd == 64'h0 && status == 2'b11 && ds_seen - s0 == TO, "R13 timeout status",
        64'(ds_seen - s0), 64'(TO));
    no_ack = 0;
    @(negedge clk);
    chk(!ds_req && !mmio_ready, "R14 idle after timeout", {62'h0, ds_req, mmio_ready}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule